// File: doc/BRIEF.md
# Three-Bank Interleaved Read Front End

This block sits in front of three memory banks, each holding 2-byte words, and turns a byte-addressed read request into a read strobe and word offset on exactly one bank. A mode input selects how the 768-byte space is spread over the banks. In block mode each bank owns one 256-byte region. In rotate mode consecutive words go to consecutive banks, so a linear walk touches bank 0, 1, 2, 0, 1, 2 and so on. The bank and offset in rotate mode come from a bit-serial divide-by-three network, not from a divider.

Every bank needs time to recover after a read. A per-bank countdown timer models this. A request aimed at a recovering bank sees ready held low until that bank's timer runs out. Requests to other banks go through at once. Read data comes back one cycle after the request is accepted. A linear walk therefore runs at one word per cycle in rotate mode but stalls in block mode.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, rsp_valid_o is low and no bank strobe is driven, and every in-range address sees req_ready_o high.
- R2: With map_mode_i = 0 (block mode), bank = addr[9:8] and in-bank word offset = addr[7:1].
- R3: With map_mode_i = 1 (rotate mode), with w = addr[9:1], bank = w mod 3 and in-bank word offset = w div 3.
- R4: Address bit 0 is ignored: an odd address reads the same bank, offset and data as the even address below it.
- R5: A request accepted at a clock edge (req_valid_i and req_ready_o both high) gives rsp_valid_o high in the next cycle, with rsp_data_o equal to the selected bank's data. rsp_valid_o is low in every other cycle.
- R6: bank_rd_o has at most one bit set. Bit b is set only in a cycle where an in-range request to bank b is accepted, and bank_addr_o slice b (7 bits, bank 0 in the low bits) then carries the in-bank word offset.
- R7: After a read is accepted by bank b at edge k, req_ready_o is low for any request to bank b until edge k+RECOVER+1. That is the earliest edge at which bank b can accept again (RECOVER = 2 by default).
- R8: A recovering bank never lowers req_ready_o for a request aimed at a different, idle bank.
- R9: An address at or above 0x300 is accepted at once. It strobes no bank and returns rsp_data_o = 0.
- R10: With RECOVER = 2, twelve reads at byte addresses 0, 2, 4 and so on, presented back to back, take 12 cycles in rotate mode and 34 cycles in block mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_mode_i | input | 1 | 0 = block mapping, 1 = rotate (modulo-3) mapping |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | 10 | Byte address of the read |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 16 | Read data word |
| bank_rd_o | output | 3 | Per-bank read strobe |
| bank_addr_o | output | 21 | Per-bank word offset, 7 bits per bank |
| bank_data_i | input | 48 | Per-bank read data, 16 bits per bank, valid the cycle after the strobe |

## Verification
A linear walk of twelve words is run in each mode. Counting its cycles separates rotated bank placement, which never stalls, from block placement, which waits out the recovery time on every word. Random traffic mixes both modes, odd addresses, idle gaps and out-of-range addresses. It is checked against a mapping model built from plain division and a per-bank model of the last acceptance time, so a wrong bank or offset shows up as wrong data, and a wrong recovery window shows up as a ready mismatch. Directed pairs aimed at the same bank and then at a neighbouring bank separate a correct per-bank stall from a global one.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int NBANK = 3;

    typedef enum logic {
        MAP_BLOCK  = 1'b0,
        MAP_ROTATE = 1'b1
    } map_mode_e;

    // Restoring division by three, one bit per step, MSB first.
    // Returns {remainder[1:0], quotient[15:0]}.
    function automatic logic [17:0] divmod3(input logic [15:0] n);
        logic [1:0]  rem;
        logic [2:0]  t;
        logic [15:0] q;
        rem = 2'd0;
        q   = 16'd0;
        for (int i = 15; i >= 0; i--) begin
            t = {rem, n[i]};
            if (t >= 3'd3) begin
                q[i] = 1'b1;
                t    = t - 3'd3;
            end
            rem = t[1:0];
        end
        return {rem, q};
    endfunction

endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map
    import ilv_pkg::*;
#(
    parameter int AW         = 10,
    parameter int BANK_BYTES = 256,
    localparam int BSH       = $clog2(BANK_BYTES),
    localparam int OFFW      = BSH - 1
) (
    input  logic            mode_i,
    input  logic [AW-1:0]   addr_i,
    output logic [1:0]      bank_o,
    output logic [OFFW-1:0] off_o,
    output logic            in_range_o
);

    localparam int SPAN = NBANK * BANK_BYTES;

    logic [AW-1:0] blk;
    logic [15:0]   word16;
    logic [17:0]   dm;

    always_comb begin
        blk    = addr_i >> BSH;
        word16 = 16'(addr_i >> 1);
        dm     = divmod3(word16);
        in_range_o = (32'(addr_i) < SPAN);
        if (map_mode_e'(mode_i) == MAP_ROTATE) begin
            bank_o = dm[17:16];
            off_o  = dm[OFFW-1:0];
        end else begin
            bank_o = blk[1:0];
            off_o  = addr_i[BSH-1:1];
        end
    end

endmodule

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
    parameter int RECOVER = 2,
    localparam int CW     = (RECOVER < 1) ? 1 : $clog2(RECOVER + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(RECOVER);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    generate
        if (RECOVER > 0) begin : g_chk
            AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |=> busy_o); // R7
        end
    endgenerate

endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 16,
    parameter int BANK_BYTES = 256,
    parameter int RECOVER    = 2,
    localparam int OFFW      = $clog2(BANK_BYTES) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                map_mode_i,
    input  logic                req_valid_i,
    input  logic [AW-1:0]       req_addr_i,
    output logic                req_ready_o,
    output logic                rsp_valid_o,
    output logic [DW-1:0]       rsp_data_o,
    output logic [NBANK-1:0]    bank_rd_o,
    output logic [NBANK*OFFW-1:0] bank_addr_o,
    input  logic [NBANK*DW-1:0] bank_data_i
);

    typedef struct packed {
        logic       rsp_valid;
        logic       rsp_zero;
        logic [1:0] rsp_bank;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]       sel_bank;
    logic [OFFW-1:0]  sel_off;
    logic             in_range;
    logic [NBANK-1:0] busy;
    logic [3:0]       busy_ext;
    logic             accept;

    ilv_addr_map #(.AW(AW), .BANK_BYTES(BANK_BYTES)) u_map (
        .mode_i     (map_mode_i),
        .addr_i     (req_addr_i),
        .bank_o     (sel_bank),
        .off_o      (sel_off),
        .in_range_o (in_range)
    );

    assign busy_ext    = {{(4-NBANK){1'b0}}, busy};
    assign req_ready_o = !in_range || !busy_ext[sel_bank];
    assign accept      = req_valid_i && req_ready_o;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            ilv_bank_timer #(.RECOVER(RECOVER)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (bank_rd_o[b]),
                .busy_o  (busy[b])
            );
            assign bank_rd_o[b] = accept && in_range && (sel_bank == 2'(b));
            assign bank_addr_o[b*OFFW +: OFFW] = sel_off;
            if (RECOVER > 0) begin : g_gap
                AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                    bank_rd_o[b] |=> !bank_rd_o[b]); // R7
            end
        end
    endgenerate

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = accept;
        if (accept) begin
            st_d.rsp_zero = !in_range;
            st_d.rsp_bank = sel_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;

    always_comb begin
        rsp_data_o = '0;
        if (!st_q.rsp_zero) begin
            case (st_q.rsp_bank)
                2'd0:    rsp_data_o = bank_data_i[0*DW +: DW];
                2'd1:    rsp_data_o = bank_data_i[1*DW +: DW];
                2'd2:    rsp_data_o = bank_data_i[2*DW +: DW];
                default: rsp_data_o = '0;
            endcase
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_rd_o)); // R6
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid_o); // R5
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !$past(!rst_n)) |-> $past(accept)); // R5
    AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !in_range) |-> (req_ready_o && bank_rd_o == '0)); // R9

endmodule

// File: tb/tb_ilv_mem_ctrl.sv
module tb_ilv_mem_ctrl;

    localparam int AW = 10, DW = 16, OFFW = 7, REC = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n, map_mode_i, req_valid_i, req_ready_o, rsp_valid_o;
    logic [AW-1:0]   req_addr_i;
    logic [DW-1:0]   rsp_data_o;
    logic [2:0]      bank_rd_o;
    logic [3*OFFW-1:0] bank_addr_o;
    logic [3*DW-1:0] bank_data_i;

    ilv_mem_ctrl #(.RECOVER(REC)) dut (
        .clk(clk), .rst_n(rst_n), .map_mode_i(map_mode_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
        .rsp_data_o(rsp_data_o), .bank_rd_o(bank_rd_o),
        .bank_addr_o(bank_addr_o), .bank_data_i(bank_data_i)
    );

    function automatic logic [15:0] content(input int b, input int o);
        return 16'(((b + 1) * 16'h1111) ^ (o * 73));
    endfunction

    // Bank memory model: data one cycle after strobe.
    always_ff @(posedge clk) begin
        for (int b = 0; b < 3; b++)
            if (bank_rd_o[b])
                bank_data_i[b*DW +: DW] <= content(b, int'(bank_addr_o[b*OFFW +: OFFW]));
    end

    int n_chk = 0, n_fail = 0, cyc = 0;
    int last_acc[3];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ref_map(input logic [AW-1:0] a, input bit m,
                           output int b, output int o, output bit inr);
        int w;
        w   = int'(a) / 2;
        inr = int'(a) < 768;
        if (m) begin b = w % 3; o = w / 3; end
        else   begin b = int'(a) / 256; o = (int'(a) % 256) / 2; end
    endtask

    // Called at a negedge; returns at the next negedge after checking the response.
    task automatic step(input bit v, input logic [AW-1:0] a, input bit m,
                        input string tag, output bit acc);
        int eb, eo; bit inr, erdy;
        req_valid_i = v; req_addr_i = a; map_mode_i = m;
        #1;
        ref_map(a, m, eb, eo, inr);
        erdy = !inr || (cyc - last_acc[eb] > REC);
        if (v) chk(req_ready_o == erdy, "R7", "ready", int'(req_ready_o), int'(erdy));
        acc = v && req_ready_o;
        for (int b = 0; b < 3; b++)
            chk(bank_rd_o[b] == (acc && inr && eb == b), "R6", "strobe", int'(bank_rd_o[b]),
                int'(acc && inr && eb == b));
        if (acc && inr) begin
            chk(int'(bank_addr_o[eb*OFFW +: OFFW]) == eo, m ? "R3" : "R2", "offset",
                int'(bank_addr_o[eb*OFFW +: OFFW]), eo);
            last_acc[eb] = cyc;
        end
        @(posedge clk); cyc++;
        @(negedge clk);
        chk(rsp_valid_o == acc, "R5", "rsp_valid", int'(rsp_valid_o), int'(acc));
        if (acc) begin
            if (inr) chk(rsp_data_o == content(eb, eo), tag, "data", int'(rsp_data_o), int'(content(eb, eo)));
            else     chk(rsp_data_o == 16'd0, "R9", "oor data", int'(rsp_data_o), 0);
        end
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, "R1", acc);
    endtask

    task automatic walk(input bit m, input int n, output int cycles);
        bit acc; int got; logic [AW-1:0] a;
        got = 0; cycles = 0; a = '0;
        while (got < n) begin
            step(1'b1, a, m, m ? "R3" : "R2", acc);
            cycles++;
            if (acc) begin got++; a = a + 10'd2; end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit acc, m;
        int cyc_rot, cyc_blk;
        logic [AW-1:0] a;
        void'($urandom(32'd2024));
        for (int b = 0; b < 3; b++) last_acc[b] = -100;
        bank_data_i = '0;
        rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0; map_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid_o), 0);
        chk(bank_rd_o == 3'b000, "R1", "strobe in reset", int'(bank_rd_o), 0);
        rst_n = 1'b1;
        req_addr_i = 10'h2FE; #1;
        chk(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
        chk(rsp_valid_o == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid_o), 0);
        @(negedge clk);

        // R10: sequential throughput
        walk(1'b1, 12, cyc_rot);
        chk(cyc_rot == 12, "R10", "rotate cycles", cyc_rot, 12);
        idle(4);
        walk(1'b0, 12, cyc_blk);
        chk(cyc_blk == 34, "R10", "block cycles", cyc_blk, 34);
        idle(4);

        // R7/R8: same bank stalls, neighbour bank does not
        step(1'b1, 10'h000, 1'b1, "R3", acc);
        step(1'b1, 10'h006, 1'b1, "R7", acc);
        chk(acc == 1'b0, "R7", "same bank held", int'(acc), 0);
        step(1'b1, 10'h002, 1'b1, "R8", acc);
        chk(acc == 1'b1, "R8", "other bank accepted", int'(acc), 1);
        step(1'b1, 10'h006, 1'b1, "R7", acc);
        chk(acc == 1'b1, "R7", "same bank after recovery", int'(acc), 1);
        idle(4);

        // R4: odd addresses
        step(1'b1, 10'h10B, 1'b0, "R4", acc);
        step(1'b1, 10'h00F, 1'b1, "R4", acc);
        step(1'b1, 10'h2FF, 1'b1, "R4", acc);
        idle(4);

        // R9: out of range, even right after a busy bank
        step(1'b1, 10'h000, 1'b0, "R2", acc);
        step(1'b1, 10'h300, 1'b0, "R9", acc);
        chk(acc == 1'b1, "R9", "oor accepted", int'(acc), 1);
        step(1'b1, 10'h3FE, 1'b1, "R9", acc);
        chk(acc == 1'b1, "R9", "oor accepted rotate", int'(acc), 1);
        idle(4);

        // Random mix
        m = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 19) == 0) m = ~m;
            if ($urandom_range(0, 19) == 0) a = AW'($urandom_range(768, 1023));
            else                            a = AW'($urandom_range(0, 767));
            step($urandom_range(0, 9) < 8, a, m, m ? "R3" : "R2", acc);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule